// File: doc/BRIEF.md
# ADC Result Conditioner with Window Monitor

This block sits between an ADC core and the result register. It takes one raw conversion sample per valid strobe, interprets it as unsigned (single-ended) or two's complement (differential), and, if correction is on, removes an offset and applies a gain. It then cuts the value to the selected resolution and places it in a 16-bit result word, either aligned at the bottom or at the top. The finished word is compared against a lower and an upper threshold under one of four window modes, and a window flag is produced alongside the result.

The configuration inputs are sampled together with each accepted sample. A sample that goes through correction leaves the block 13 cycles later than one that does not. Every corrected sample in flight keeps the configuration it was accepted with. If a delayed corrected result and a direct uncorrected result would leave in the same cycle, the delayed one is output.

Top module: `adc_result_conditioner`

## Requirements
- R1: During and right after reset, res_valid, win_hit and res_data are all zero.
- R2: With corr_en low at acceptance, res_valid pulses for one cycle on the clock edge that accepts the sample (one register), once per sample.
- R3: With corr_en high at acceptance, the result appears 13 cycles later than in R2, and res_valid stays low in the cycles between.
- R4: Only smp_data[11:0] is used outside pass-through. It is unsigned when diff_mode is 0 and 12-bit two's complement when diff_mode is 1. smp_data[15:12] has no effect.
- R5: With correction, the value becomes floor((x - offset_val) * gain_val / 2048). offset_val is signed 12-bit and gain_val is unsigned 12-bit, with 2048 meaning 1.0. The value saturates to 0..4095 (single-ended) or -2048..2047 (differential).
- R6: res_sel code 0 keeps all 12 bits, code 2 drops the two lowest bits (10-bit), code 3 drops the four lowest bits (8-bit).
- R7: res_sel code 1 passes all 16 sample bits to res_data unchanged, with no correction and no justification.
- R8: With left_adj low, the reduced value sits in the low bits. The upper bits are zero in single-ended mode and copies of the sign bit in differential mode.
- R9: With left_adj high, the reduced value's MSB is bit 15 and all bits below it are zero.
- R10: Window codes: 1 flags result > thr_lo; 2 flags result < thr_hi; 3 flags thr_lo < result < thr_hi; 4 flags thr_hi < result < thr_lo. All comparisons are strict.
- R11: Window code 0 and the reserved codes 5, 6 and 7 never raise win_hit.
- R12: Window comparisons use the final 16-bit word. They are signed when diff_mode is 1 and unsigned otherwise.
- R13: win_hit is registered with res_valid and is high only while res_valid is high.
- R14: Configuration changes after acceptance do not alter a result still in flight. Back-to-back corrected samples come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_data | input | 16 | Raw sample (12 bits used, 16 in pass-through) |
| diff_mode | input | 1 | 1: differential (signed), 0: single-ended |
| corr_en | input | 1 | Enables offset and gain correction |
| res_sel | input | 2 | Resolution: 0=12, 1=16 pass-through, 2=10, 3=8 bits |
| left_adj | input | 1 | 1: top-aligned result |
| win_mode | input | 3 | Window mode code |
| thr_lo | input | 16 | Lower threshold |
| thr_hi | input | 16 | Upper threshold |
| gain_val | input | 12 | Unsigned gain, 2048 = 1.0 |
| offset_val | input | 12 | Signed offset subtracted first |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Justified result word |
| win_hit | output | 1 | Window condition met |

## Verification
The assertions check, on every cycle, that both the direct and the delayed path reach the output in the fixed number of cycles. They also check that pass-through copies the sample, that the bits outside the justified field are zero, that code 0 and the reserved window codes stay silent, and that the flag never appears without the strobe. The correction arithmetic with its saturation, the signed/unsigned choice of comparison, the strict window bounds and the ordering of overlapping corrected samples under changing configuration are shown only by the bench's scenarios. Those scenarios are checked against a reference function.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;
    localparam int RAW_W = 12;
    localparam int RES_W = 16;
    localparam int FRAC_W = 11;

    typedef enum logic [2:0] {
        WIN_OFF    = 3'd0,
        WIN_ABOVE  = 3'd1,
        WIN_BELOW  = 3'd2,
        WIN_INSIDE = 3'd3,
        WIN_INVERT = 3'd4
    } win_mode_e;

    typedef enum logic [1:0] {
        RES_12  = 2'd0,
        RES_16  = 2'd1,
        RES_10  = 2'd2,
        RES_8   = 2'd3
    } res_sel_e;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] data;
        logic             hit;
    } res_ent_t;
endpackage

// File: rtl/adc_corr_unit.sv
module adc_corr_unit #(
    parameter int RAW_W  = adc_cond_pkg::RAW_W,
    parameter int FRAC_W = adc_cond_pkg::FRAC_W
) (
    input  logic [RAW_W-1:0] raw_i,
    input  logic             diff_i,
    input  logic             corr_i,
    input  logic [RAW_W-1:0] gain_i,
    input  logic [RAW_W-1:0] offs_i,
    output logic [RAW_W-1:0] val_o
);
    localparam int EXT_W  = RAW_W + 2;
    localparam int PROD_W = EXT_W + RAW_W + 1;
    localparam logic signed [PROD_W-1:0] U_MAX = PROD_W'((1 << RAW_W) - 1);
    localparam logic signed [PROD_W-1:0] S_MAX = PROD_W'((1 << (RAW_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] S_MIN = -PROD_W'(1 << (RAW_W - 1));

    logic signed [EXT_W-1:0]  x_ext;
    logic signed [EXT_W-1:0]  o_ext;
    logic signed [EXT_W-1:0]  diffv;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        x_ext  = diff_i ? {{2{raw_i[RAW_W-1]}}, raw_i} : {2'b00, raw_i};
        o_ext  = {{2{offs_i[RAW_W-1]}}, offs_i};
        diffv  = x_ext - o_ext;
        prod   = $signed({{(PROD_W-EXT_W){diffv[EXT_W-1]}}, diffv})
               * $signed({{(PROD_W-RAW_W){1'b0}}, gain_i});
        scaled = prod >>> FRAC_W;
        if (!corr_i) begin
            val_o = raw_i;
        end else if (diff_i) begin
            if (scaled > S_MAX)      val_o = S_MAX[RAW_W-1:0];
            else if (scaled < S_MIN) val_o = S_MIN[RAW_W-1:0];
            else                     val_o = scaled[RAW_W-1:0];
        end else begin
            if (scaled > U_MAX)      val_o = U_MAX[RAW_W-1:0];
            else if (scaled < 0)     val_o = '0;
            else                     val_o = scaled[RAW_W-1:0];
        end
    end
endmodule

// File: rtl/adc_justify.sv
module adc_justify #(
    parameter int RAW_W = adc_cond_pkg::RAW_W,
    parameter int RES_W = adc_cond_pkg::RES_W
) (
    input  logic [RAW_W-1:0] val_i,
    input  logic [RES_W-1:0] pass_i,
    input  logic             diff_i,
    input  logic             left_i,
    input  logic [1:0]       sel_i,
    output logic [RES_W-1:0] word_o
);
    import adc_cond_pkg::*;
    localparam int PAD = RES_W - RAW_W;

    logic [3:0]       drop;
    logic [RES_W-1:0] ext;
    logic [RES_W-1:0] top;

    always_comb begin
        case (res_sel_e'(sel_i))
            RES_10:  drop = 4'd2;
            RES_8:   drop = 4'd4;
            default: drop = 4'd0;
        endcase
        ext = diff_i ? {{PAD{val_i[RAW_W-1]}}, val_i} : {{PAD{1'b0}}, val_i};
        top = {val_i, {PAD{1'b0}}};
        if (res_sel_e'(sel_i) == RES_16) begin
            word_o = pass_i;
        end else if (left_i) begin
            word_o = (top >> (PAD + int'(drop))) << (PAD + int'(drop));
        end else if (diff_i) begin
            word_o = RES_W'($signed(ext) >>> drop);
        end else begin
            word_o = ext >> drop;
        end
    end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
    parameter int RES_W = adc_cond_pkg::RES_W
) (
    input  logic [RES_W-1:0] word_i,
    input  logic [RES_W-1:0] lo_i,
    input  logic [RES_W-1:0] hi_i,
    input  logic             diff_i,
    input  logic [2:0]       mode_i,
    output logic             hit_o
);
    import adc_cond_pkg::*;

    logic above_lo, below_hi, above_hi, below_lo;

    always_comb begin
        if (diff_i) begin
            above_lo = $signed(word_i) > $signed(lo_i);
            below_lo = $signed(word_i) < $signed(lo_i);
            above_hi = $signed(word_i) > $signed(hi_i);
            below_hi = $signed(word_i) < $signed(hi_i);
        end else begin
            above_lo = word_i > lo_i;
            below_lo = word_i < lo_i;
            above_hi = word_i > hi_i;
            below_hi = word_i < hi_i;
        end
        case (mode_i)
            WIN_ABOVE:  hit_o = above_lo;
            WIN_BELOW:  hit_o = below_hi;
            WIN_INSIDE: hit_o = above_lo && below_hi;
            WIN_INVERT: hit_o = above_hi && below_lo;
            default:    hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_result_conditioner.sv
module adc_result_conditioner #(
    parameter int RAW_W    = adc_cond_pkg::RAW_W,
    parameter int RES_W    = adc_cond_pkg::RES_W,
    parameter int CORR_LAT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [RES_W-1:0] smp_data,
    input  logic             diff_mode,
    input  logic             corr_en,
    input  logic [1:0]       res_sel,
    input  logic             left_adj,
    input  logic [2:0]       win_mode,
    input  logic [RES_W-1:0] thr_lo,
    input  logic [RES_W-1:0] thr_hi,
    input  logic [RAW_W-1:0] gain_val,
    input  logic [RAW_W-1:0] offset_val,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             win_hit
);
    import adc_cond_pkg::*;
    localparam int DL_N = CORR_LAT;

    typedef struct packed {
        res_ent_t [DL_N-1:0] dl;
        res_ent_t            out;
    } state_t;

    state_t st_d, st_q;

    logic [RAW_W-1:0] corr_val;
    logic [RES_W-1:0] word;
    logic             hit;
    res_ent_t         cur;

    adc_corr_unit #(.RAW_W(RAW_W)) corr_i (
        .raw_i  (smp_data[RAW_W-1:0]),
        .diff_i (diff_mode),
        .corr_i (corr_en),
        .gain_i (gain_val),
        .offs_i (offset_val),
        .val_o  (corr_val)
    );

    adc_justify #(.RAW_W(RAW_W), .RES_W(RES_W)) just_i (
        .val_i  (corr_val),
        .pass_i (smp_data),
        .diff_i (diff_mode),
        .left_i (left_adj),
        .sel_i  (res_sel),
        .word_o (word)
    );

    adc_window_cmp #(.RES_W(RES_W)) win_i (
        .word_i (word),
        .lo_i   (thr_lo),
        .hi_i   (thr_hi),
        .diff_i (diff_mode),
        .mode_i (win_mode),
        .hit_o  (hit)
    );

    always_comb begin
        st_d     = st_q;
        cur.vld  = smp_valid;
        cur.data = smp_valid ? word : '0;
        cur.hit  = smp_valid && hit;

        st_d.dl[0] = (smp_valid && corr_en) ? cur : '0;
        for (int i = 1; i < DL_N; i++) begin
            st_d.dl[i] = st_q.dl[i-1];
        end

        if (st_q.dl[DL_N-1].vld) begin
            st_d.out = st_q.dl[DL_N-1];
        end else if (smp_valid && !corr_en) begin
            st_d.out = cur;
        end else begin
            st_d.out = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.out.vld;
    assign res_data  = st_q.out.data;
    assign win_hit   = st_q.out.hit;
endmodule

// File: rtl/adc_result_conditioner_chk.sv
module adc_result_conditioner_chk #(
    parameter int RAW_W    = adc_cond_pkg::RAW_W,
    parameter int RES_W    = adc_cond_pkg::RES_W,
    parameter int CORR_LAT = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [RES_W-1:0] smp_data,
    input logic             diff_mode,
    input logic             corr_en,
    input logic [1:0]       res_sel,
    input logic             left_adj,
    input logic [2:0]       win_mode,
    input logic [RES_W-1:0] thr_lo,
    input logic [RES_W-1:0] thr_hi,
    input logic [RAW_W-1:0] gain_val,
    input logic [RAW_W-1:0] offset_val,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data,
    input logic             win_hit
);
    logic [CORR_LAT-1:0] trk_q;
    logic                direct;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= {trk_q[CORR_LAT-2:0], smp_valid && corr_en};
    end

    assign direct = smp_valid && !corr_en && !trk_q[CORR_LAT-1];

    p_plain_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !corr_en |=> res_valid);

    p_corr_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q[CORR_LAT-1] |=> res_valid);

    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        direct && res_sel == 2'd1 |=> res_data == $past(smp_data));

    p_right_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        direct && res_sel == 2'd3 && !left_adj && !diff_mode |=> res_data[RES_W-1:8] == '0);

    p_left_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        direct && res_sel == 2'd3 && left_adj |=> res_data[7:0] == '0);

    p_reserved_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        direct && (win_mode == 3'd0 || win_mode > 3'd4) |=> !win_hit);

    p_flag_with_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> res_valid);
endmodule

bind adc_result_conditioner adc_result_conditioner_chk #(
    .RAW_W(RAW_W), .RES_W(RES_W), .CORR_LAT(CORR_LAT)
) chk_i (.*);

// File: tb/adc_result_conditioner_tb_top.sv
module adc_result_conditioner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        diff_mode = 1'b0;
    logic        corr_en = 1'b0;
    logic [1:0]  res_sel = '0;
    logic        left_adj = 1'b0;
    logic [2:0]  win_mode = '0;
    logic [15:0] thr_lo = '0;
    logic [15:0] thr_hi = '0;
    logic [11:0] gain_val = 12'h800;
    logic [11:0] offset_val = '0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        win_hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_result_conditioner dut_i (.*);

    function automatic logic [16:0] ref_out(input logic [15:0] s, input logic dm, input logic ce,
                                            input logic [1:0] rs, input logic la, input logic [2:0] wm,
                                            input logic [15:0] lo, input logic [15:0] hi,
                                            input logic [11:0] g, input logic [11:0] off);
        int x, v, t, drop, wa, loa, hia;
        logic [15:0] w;
        logic f;
        x = dm ? int'($signed(s[11:0])) : int'(s[11:0]);
        if (rs == 2'd1) begin
            w = s;
        end else begin
            v = x;
            if (ce) begin
                t = (x - int'($signed(off))) * int'(g);
                v = t >>> 11;
                if (dm) begin
                    if (v > 2047) v = 2047;
                    if (v < -2048) v = -2048;
                end else begin
                    if (v > 4095) v = 4095;
                    if (v < 0) v = 0;
                end
            end
            drop = (rs == 2'd2) ? 2 : (rs == 2'd3) ? 4 : 0;
            if (la) w = 16'((v >>> drop) << (4 + drop));
            else    w = 16'(v >>> drop);
        end
        wa  = dm ? int'($signed(w))  : int'(w);
        loa = dm ? int'($signed(lo)) : int'(lo);
        hia = dm ? int'($signed(hi)) : int'(hi);
        case (wm)
            3'd1: f = wa > loa;
            3'd2: f = wa < hia;
            3'd3: f = (loa < wa) && (wa < hia);
            3'd4: f = (hia < wa) && (wa < loa);
            default: f = 1'b0;
        endcase
        return {f, w};
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scramble();
        diff_mode  = 1'($urandom);
        corr_en    = 1'($urandom);
        res_sel    = 2'($urandom);
        left_adj   = 1'($urandom);
        win_mode   = 3'($urandom);
        thr_lo     = 16'($urandom);
        thr_hi     = 16'($urandom);
        gain_val   = 12'($urandom);
        offset_val = 12'($urandom);
        smp_data   = 16'($urandom);
    endtask

    // Drives one sample with the given config, scrambles config, checks the result and its timing.
    task automatic run_one(input string req, input logic [15:0] s, input logic dm, input logic ce,
                           input logic [1:0] rs, input logic la, input logic [2:0] wm,
                           input logic [15:0] lo, input logic [15:0] hi,
                           input logic [11:0] g, input logic [11:0] off);
        logic [16:0] e;
        e = ref_out(s, dm, ce, rs, la, wm, lo, hi, g, off);
        @(negedge clk);
        smp_data = s; diff_mode = dm; corr_en = ce; res_sel = rs; left_adj = la;
        win_mode = wm; thr_lo = lo; thr_hi = hi; gain_val = g; offset_val = off;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        scramble();
        if (ce) begin
            for (int i = 0; i < 13; i++) begin
                check("R3 quiet gap", {17'b0, res_valid}, 18'd0);
                @(negedge clk);
            end
        end
        check(req, {res_valid, win_hit, res_data}, {1'b1, e});
        @(negedge clk);
        check("R2 single pulse", {17'b0, res_valid}, 18'd0);
    endtask

    logic [16:0] bexp [5];

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset", {res_valid, win_hit, res_data}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {res_valid, win_hit, res_data}, 18'd0);

        run_one("R2 R6 12-bit right", 16'h0ABC, 0, 0, 2'd0, 0, 3'd0, 0, 0, 12'h800, 0);
        run_one("R4 upper bits ignored", 16'hFABC, 0, 0, 2'd0, 0, 3'd0, 0, 0, 12'h800, 0);
        run_one("R9 R6 8-bit left", 16'h0ABC, 0, 0, 2'd3, 1, 3'd0, 0, 0, 12'h800, 0);
        run_one("R6 10-bit right", 16'h0ABC, 0, 0, 2'd2, 0, 3'd0, 0, 0, 12'h800, 0);
        run_one("R9 10-bit left", 16'h0ABC, 0, 0, 2'd2, 1, 3'd0, 0, 0, 12'h800, 0);
        run_one("R8 diff sign extend", 16'h0800, 1, 0, 2'd0, 0, 3'd0, 0, 0, 12'h800, 0);
        run_one("R8 diff 8-bit right", 16'h0800, 1, 0, 2'd3, 0, 3'd0, 0, 0, 12'h800, 0);
        run_one("R7 pass-through", 16'h1234, 0, 0, 2'd1, 1, 3'd0, 0, 0, 12'h400, 12'h123);
        run_one("R5 R3 offset", 16'h0100, 0, 1, 2'd0, 0, 3'd0, 0, 0, 12'h800, 12'h010);
        run_one("R5 half gain", 16'h0200, 0, 1, 2'd0, 0, 3'd0, 0, 0, 12'h400, 0);
        run_one("R5 saturate high", 16'h0FFF, 0, 1, 2'd0, 0, 3'd0, 0, 0, 12'hFFF, 12'hF00);
        run_one("R5 saturate zero", 16'h0005, 0, 1, 2'd0, 0, 3'd0, 0, 0, 12'h800, 12'h064);
        run_one("R5 diff saturate low", 16'h0800, 1, 1, 2'd0, 0, 3'd0, 0, 0, 12'h800, 12'h001);
        run_one("R10 mode1 strict", 16'h0100, 0, 0, 2'd0, 0, 3'd1, 16'h0100, 0, 12'h800, 0);
        run_one("R10 mode1 above", 16'h0101, 0, 0, 2'd0, 0, 3'd1, 16'h0100, 0, 12'h800, 0);
        run_one("R10 mode3 inside", 16'h0150, 0, 0, 2'd0, 0, 3'd3, 16'h0100, 16'h0200, 12'h800, 0);
        run_one("R10 mode4 inverted", 16'h0180, 0, 0, 2'd0, 0, 3'd4, 16'h0200, 16'h0100, 12'h800, 0);
        run_one("R11 reserved code", 16'h0180, 0, 0, 2'd0, 0, 3'd5, 16'h0000, 16'hFFFF, 12'h800, 0);
        run_one("R11 mode off", 16'h0180, 0, 0, 2'd0, 0, 3'd0, 16'h0000, 16'hFFFF, 12'h800, 0);
        run_one("R12 signed compare", 16'h0FFF, 1, 0, 2'd0, 0, 3'd2, 0, 16'h0001, 12'h800, 0);
        run_one("R12 unsigned compare", 16'h0FFF, 0, 0, 2'd0, 0, 3'd2, 0, 16'h0001, 12'h800, 0);

        // R14: back-to-back corrected samples with a new config each cycle
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            scramble();
            corr_en = 1'b1;
            smp_valid = 1'b1;
            bexp[k] = ref_out(smp_data, diff_mode, 1'b1, res_sel, left_adj, win_mode,
                              thr_lo, thr_hi, gain_val, offset_val);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        scramble();
        for (int w = 0; w < 30 && !res_valid; w++) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            check("R14 in-order burst", {res_valid, win_hit, res_data}, {1'b1, bexp[k]});
            @(negedge clk);
        end

        // R13 and mixed: random samples
        for (int n = 0; n < 400; n++) begin
            run_one("R13 random", 16'($urandom), 1'($urandom), (n % 4) == 0, 2'($urandom),
                    1'($urandom), 3'($urandom), 16'($urandom), 16'($urandom),
                    12'($urandom), 12'($urandom));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule